// File: doc/BRIEF.md
# Multi-source reset controller with cause register

This block gathers every reset request of a small system and turns it into seven separate active-low reset outputs: a core power-on reset, a core system reset, a debug-port reset, a main bus reset and three peripheral bus resets. Each output has its own set of sources. Power-on and low-voltage detection reset everything. The external reset pin and the pulse-type causes (two watchdogs, a clock-failure monitor, an abnormal-frequency monitor and a software request) reset the system outputs but leave the core power-on and debug-port resets alone. A separate debug pin resets only the debug port. Every output is asserted asynchronously and released through its own synchronizer in the `clk_i` domain.

Pulse-type causes are single-cycle strobes synchronous to `clk_i`. A down-counter stretches them so that the system reset lasts at least `STRETCH` cycles. The external pin and the low-voltage detector are level causes and hold reset for as long as they are active.

A small register port gives software two registers. Address 0 holds the sticky reset-cause flags and is cleared by reading it. Address 1 is a control register with a software-reset request bit and two hold bits, one for each of the last two peripheral bus resets. The cause flags survive every reset except a power-on-class one (power-on or low-voltage). The control register is cleared by any system reset.

Top module: `rst_ctrl`

## Requirements
- R1: `core_por_rst_no` is low while `rst_ni` is low or `lvd_i` is high, for as long as either lasts. No other source affects it.
- R2: `core_sys_rst_no`, `bus_rst_no` and `periph_rst_no[0]` always carry the same value. They go low on any of the eight system causes: power-on, low voltage, external pin, software watchdog, hardware watchdog, clock failure, abnormal frequency and software request.
- R3: `dbg_rst_no` is low only for power-on, low voltage or `dbg_rst_ni` low. The external reset pin and the pulse causes leave it high, and `dbg_rst_ni` touches neither the system outputs nor the cause register.
- R4: Cause register (address 0) bit positions: 0 power-on or low voltage, 1 external pin, 4 software watchdog, 5 hardware watchdog, 6 clock failure, 7 abnormal frequency, 8 software request. All other bits read 0. It reads 0x001 after a power-on-class reset.
- R5: A cause other than power-on-class sets its own flag and leaves earlier flags set. Only a power-on-class reset returns the register to 0x001.
- R6: `ext_rst_ni` low asserts the system outputs immediately and holds them for as long as the pin stays low.
- R7: A one-cycle strobe on `swdg_i`, `hwdg_i`, `clk_fail_i` or `freq_err_i` pulls the system outputs low after the clock edge that samples it. They stay low for `STRETCH`+1 further edges and rise on the edge after those.
- R8: Control register (address 1) bits 1 and 2 hold `periph_rst_no[1]` and `periph_rst_no[2]` in reset. No other output is affected. The bits read back at the same positions.
- R9: Writing 1 to control bit 0 requests a software reset. The system outputs go low one cycle after the write edge, and the bit reads back 0 once the reset has been issued.
- R10: A read of address 0 returns the flags and clears them on that clock edge. A cause arriving on that edge still sets its flag.
- R11: Any system reset clears all control-register bits to 0.
- R12: Every output is asserted without waiting for a clock edge. It is released on the `SYNC_STAGES`-th rising edge after its last cause goes away (2 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for synchronizers, stretcher and registers |
| rst_ni | input | 1 | Power-on detector, active low, asynchronous |
| lvd_i | input | 1 | Low-voltage detector, active high level |
| ext_rst_ni | input | 1 | External system reset pin, active low |
| dbg_rst_ni | input | 1 | External debug reset pin, active low |
| swdg_i | input | 1 | Software watchdog expiry strobe |
| hwdg_i | input | 1 | Hardware watchdog expiry strobe |
| clk_fail_i | input | 1 | Clock-failure monitor strobe |
| freq_err_i | input | 1 | Abnormal-frequency monitor strobe |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (clears cause register at address 0) |
| reg_addr_i | input | 1 | Register select: 0 cause, 1 control |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register |
| core_por_rst_no | output | 1 | Core power-on reset, active low |
| core_sys_rst_no | output | 1 | Core system reset, active low |
| dbg_rst_no | output | 1 | Debug-port reset, active low |
| bus_rst_no | output | 1 | Main bus reset, active low |
| periph_rst_no | output | 3 | Peripheral bus resets, active low; [2:1] software holdable |

## Verification
The bench drives each source in turn: the power-on input, a long low-voltage level, the external pin held for several cycles, a single-cycle strobe on each of the four monitor and watchdog inputs, the software request write and the debug pin. It compares the full seven-bit output vector each time, so a source wired into the wrong output group stands out from one wired correctly. Pulse causes are timed edge by edge to separate a correct stretch length from one that is one cycle off. Cause flags are read after several causes have piled up and again after a power-on-class event, which shows the difference between sticky, cleared-on-read and power-on-only initialisation.

// File: rtl/rst_ctrl_pkg.sv
`timescale 1ns/1ps
package rst_ctrl_pkg;
  // cause register bit positions (software decodes these)
  localparam int unsigned CB_POR  = 0;
  localparam int unsigned CB_EXT  = 1;
  localparam int unsigned CB_SWDG = 4;
  localparam int unsigned CB_HWDG = 5;
  localparam int unsigned CB_CLKF = 6;
  localparam int unsigned CB_FREQ = 7;
  localparam int unsigned CB_SWRQ = 8;

  // control register bit positions
  localparam int unsigned CTL_SWRQ  = 0;
  localparam int unsigned CTL_HOLD1 = 1;
  localparam int unsigned CTL_HOLD2 = 2;

  localparam logic ADDR_CAUSE = 1'b0;
  localparam logic ADDR_CTRL  = 1'b1;

  typedef enum logic [2:0] {
    OUT_CPOR = 3'd0,
    OUT_CSYS = 3'd1,
    OUT_DBG  = 3'd2,
    OUT_BUS  = 3'd3,
    OUT_PB0  = 3'd4,
    OUT_PB1  = 3'd5,
    OUT_PB2  = 3'd6
  } rst_out_e;

  localparam int unsigned N_OUT = 7;
endpackage

// File: rtl/rst_ctrl_sync.sv
`timescale 1ns/1ps
module rst_ctrl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) q <= '0;
    else          q <= {q[STAGES-2:0], 1'b1};
  end

  assign rst_no = q[STAGES-1];
endmodule

// File: rtl/rst_ctrl_stretch.sv
`timescale 1ns/1ps
module rst_ctrl_stretch #(
  parameter int unsigned LEN = 16,
  localparam int unsigned CW = $clog2(LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pulse_i,
  output logic active_o
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt <= '0;
    else if (pulse_i)         cnt <= CW'(LEN);
    else if (cnt != '0)       cnt <= cnt - CW'(1);
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/rst_ctrl_cause.sv
`timescale 1ns/1ps
module rst_ctrl_cause
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,      // power-on class only
  input  logic              ext_rst_ni,
  input  logic [DATA_W-1:0] set_i,
  input  logic              clr_i,
  output logic [DATA_W-1:0] cause_o
);
  localparam logic [DATA_W-1:0] INIT = DATA_W'(1) << CB_POR;

  logic [1:0]        ext_q;
  logic [DATA_W-1:0] flags, flags_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ext_q <= 2'b11;
    else         ext_q <= {ext_q[0], ext_rst_ni};
  end

  always_comb begin
    flags_d = clr_i ? '0 : flags;
    flags_d = flags_d | set_i;
    flags_d[CB_EXT] = flags_d[CB_EXT] | ~ext_q[1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags <= INIT;
    else         flags <= flags_d;
  end

  assign cause_o = flags;
endmodule

// File: rtl/rst_ctrl.sv
`timescale 1ns/1ps
module rst_ctrl
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned STRETCH     = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvd_i,
  input  logic              ext_rst_ni,
  input  logic              dbg_rst_ni,
  input  logic              swdg_i,
  input  logic              hwdg_i,
  input  logic              clk_fail_i,
  input  logic              freq_err_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic              reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              core_por_rst_no,
  output logic              core_sys_rst_no,
  output logic              dbg_rst_no,
  output logic              bus_rst_no,
  output logic [2:0]        periph_rst_no
);
  logic              por_cls_n;
  logic              stretch_act;
  logic              sys_req;
  logic              sw_req_q, hold1_q, hold2_q;
  logic [N_OUT-1:0]  req, req_n, rst_n;
  logic [DATA_W-1:0] set_v, cause;
  logic              unused_wdata;

  assign por_cls_n    = rst_ni & ~lvd_i;
  assign unused_wdata = ^reg_wdata_i[DATA_W-1:3];

  rst_ctrl_stretch #(.LEN(STRETCH)) u_stretch (
    .clk_i   (clk_i),
    .rst_ni  (por_cls_n),
    .pulse_i (swdg_i | hwdg_i | clk_fail_i | freq_err_i | sw_req_q),
    .active_o(stretch_act)
  );

  assign sys_req = ~por_cls_n | ~ext_rst_ni | stretch_act;

  always_comb begin
    req           = '0;
    req[OUT_CPOR] = ~por_cls_n;
    req[OUT_CSYS] = sys_req;
    req[OUT_DBG]  = ~por_cls_n | ~dbg_rst_ni;
    req[OUT_BUS]  = sys_req;
    req[OUT_PB0]  = sys_req;
    req[OUT_PB1]  = sys_req | hold1_q;
    req[OUT_PB2]  = sys_req | hold2_q;
  end

  assign req_n = ~req;

  for (genvar i = 0; i < N_OUT; i++) begin : g_sync
    rst_ctrl_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .arst_ni(req_n[i]),
      .rst_no (rst_n[i])
    );
  end

  assign core_por_rst_no  = rst_n[OUT_CPOR];
  assign core_sys_rst_no  = rst_n[OUT_CSYS];
  assign dbg_rst_no       = rst_n[OUT_DBG];
  assign bus_rst_no       = rst_n[OUT_BUS];
  assign periph_rst_no[0] = rst_n[OUT_PB0];
  assign periph_rst_no[1] = rst_n[OUT_PB1];
  assign periph_rst_no[2] = rst_n[OUT_PB2];

  // control register: cleared by the issued system reset, which also retires sw_req
  always_ff @(posedge clk_i or negedge rst_n[OUT_CSYS]) begin
    if (!rst_n[OUT_CSYS]) begin
      sw_req_q <= 1'b0;
      hold1_q  <= 1'b0;
      hold2_q  <= 1'b0;
    end else if (reg_we_i && reg_addr_i == ADDR_CTRL) begin
      sw_req_q <= reg_wdata_i[CTL_SWRQ];
      hold1_q  <= reg_wdata_i[CTL_HOLD1];
      hold2_q  <= reg_wdata_i[CTL_HOLD2];
    end
  end

  always_comb begin
    set_v          = '0;
    set_v[CB_SWDG] = swdg_i;
    set_v[CB_HWDG] = hwdg_i;
    set_v[CB_CLKF] = clk_fail_i;
    set_v[CB_FREQ] = freq_err_i;
    set_v[CB_SWRQ] = sw_req_q;
  end

  rst_ctrl_cause #(.DATA_W(DATA_W)) u_cause (
    .clk_i     (clk_i),
    .rst_ni    (por_cls_n),
    .ext_rst_ni(ext_rst_ni),
    .set_i     (set_v),
    .clr_i     (reg_re_i && reg_addr_i == ADDR_CAUSE),
    .cause_o   (cause)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == ADDR_CAUSE) begin
      reg_rdata_o = cause;
    end else begin
      reg_rdata_o[CTL_SWRQ]  = sw_req_q;
      reg_rdata_o[CTL_HOLD1] = hold1_q;
      reg_rdata_o[CTL_HOLD2] = hold2_q;
    end
  end
endmodule

// File: rtl/rst_ctrl_chk.sv
`timescale 1ns/1ps
module rst_ctrl_chk
  import rst_ctrl_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              lvd_i,
  input logic              pulse_any_i,
  input logic              reg_we_i,
  input logic              reg_addr_i,
  input logic              wr_sw_i,
  input logic              wr_hold1_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              core_por_rst_no,
  input logic              core_sys_rst_no,
  input logic              dbg_rst_no,
  input logic              bus_rst_no,
  input logic [2:0]        periph_rst_no
);
  localparam logic [DATA_W-1:0] MASK = DATA_W'((1 << CB_POR) | (1 << CB_EXT) |
    (1 << CB_SWDG) | (1 << CB_HWDG) | (1 << CB_CLKF) | (1 << CB_FREQ) | (1 << CB_SWRQ));

  assert_por_on_lvd_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lvd_i |-> !core_por_rst_no);

  assert_sys_group_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rst_no == core_sys_rst_no) && (periph_rst_no[0] == core_sys_rst_no));

  assert_por_drives_sys_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_por_rst_no |-> !core_sys_rst_no);

  assert_por_drives_dbg_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !core_por_rst_no |-> !dbg_rst_no);

  assert_cause_unused_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == ADDR_CAUSE) |-> ((reg_rdata_o & ~MASK) == '0));

  assert_pulse_asserts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pulse_any_i |=> !core_sys_rst_no);

  assert_hold_asserts_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && wr_hold1_i && core_sys_rst_no) |=> !periph_rst_no[1]);

  assert_swreq_asserts_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_CTRL && wr_sw_i && core_sys_rst_no) |=> ##1 !core_sys_rst_no);

  assert_por_release_sync_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(core_por_rst_no) |-> $past(rst_ni && !lvd_i));
endmodule

bind rst_ctrl rst_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .lvd_i          (lvd_i),
  .pulse_any_i    (swdg_i | hwdg_i | clk_fail_i | freq_err_i),
  .reg_we_i       (reg_we_i),
  .reg_addr_i     (reg_addr_i),
  .wr_sw_i        (reg_wdata_i[0]),
  .wr_hold1_i     (reg_wdata_i[1]),
  .reg_rdata_o    (reg_rdata_o),
  .core_por_rst_no(core_por_rst_no),
  .core_sys_rst_no(core_sys_rst_no),
  .dbg_rst_no     (dbg_rst_no),
  .bus_rst_no     (bus_rst_no),
  .periph_rst_no  (periph_rst_no)
);

// File: tb/rst_ctrl_test.sv
`timescale 1ns/1ps
module rst_ctrl_test;
  localparam int DW = 16;
  // output vector bit order: 0 core_por, 1 core_sys, 2 dbg, 3 bus, 4 periph0, 5 periph1, 6 periph2
  localparam logic [15:0] ALL_HI  = 16'h007f;
  localparam logic [15:0] ALL_LO  = 16'h0000;
  localparam logic [15:0] SYS_LO  = 16'h0005; // only core_por and dbg released
  localparam logic [15:0] DBG_LO  = 16'h007b;
  localparam logic [15:0] HOLD_LO = 16'h001f;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0, lvd = 1'b0, ext_n = 1'b1, dbg_n = 1'b1;
  logic          swdg = 1'b0, hwdg = 1'b0, clkf = 1'b0, freq = 1'b0;
  logic          we = 1'b0, re = 1'b0, addr = 1'b0;
  logic [DW-1:0] wdata = '0, rdata;
  logic          por_n, sys_n, dbgo_n, bus_n;
  logic [2:0]    pb_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  string       q_tag[$];
  bit          q_rd[$];
  logic [15:0] q_exp[$];

  always #5 clk = ~clk;

  rst_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .lvd_i(lvd), .ext_rst_ni(ext_n), .dbg_rst_ni(dbg_n),
    .swdg_i(swdg), .hwdg_i(hwdg), .clk_fail_i(clkf), .freq_err_i(freq),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .core_por_rst_no(por_n), .core_sys_rst_no(sys_n),
    .dbg_rst_no(dbgo_n), .bus_rst_no(bus_n), .periph_rst_no(pb_n)
  );

  function automatic logic [15:0] outs();
    return {9'd0, pb_n[2], pb_n[1], pb_n[0], bus_n, dbgo_n, sys_n, por_n};
  endfunction

  // monitor: compares queued expectations just after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q_tag.size() > 0) begin
        string t; bit r; logic [15:0] e, a;
        t = q_tag.pop_front(); r = q_rd.pop_front(); e = q_exp.pop_front();
        a = r ? rdata : outs();
        checks++;
        if (a !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic expect_out(string t, logic [15:0] e);
    q_tag.push_back(t); q_rd.push_back(1'b0); q_exp.push_back(e);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic a, logic [DW-1:0] d);
    addr = a; wdata = d; we = 1'b1;
    tick(1);
    we = 1'b0; wdata = '0;
  endtask

  task automatic rd(logic a, logic [15:0] e, string t);
    addr = a; re = 1'b1;
    q_tag.push_back(t); q_rd.push_back(1'b1); q_exp.push_back(e);
    tick(1);
    re = 1'b0;
  endtask

  task automatic strobe(int which);
    case (which)
      0: swdg = 1'b1;
      1: hwdg = 1'b1;
      2: clkf = 1'b1;
      default: freq = 1'b1;
    endcase
    tick(1);
    swdg = 1'b0; hwdg = 1'b0; clkf = 1'b0; freq = 1'b0;
  endtask

  initial begin
    tick(3);
    expect_out("R1 R2 R3 outputs during power-on", ALL_LO);
    rst_ni = 1'b1;
    expect_out("R12 held right after power-on release", ALL_LO);
    tick(1);
    expect_out("R12 held after one edge", ALL_LO);
    tick(1);
    expect_out("R12 released after two edges", ALL_HI);
    rd(1'b0, 16'h0001, "R4 cause after power-on");
    rd(1'b0, 16'h0000, "R10 cause cleared by read");

    // peripheral holds
    wr(1'b1, 16'h0006);
    expect_out("R8 holds assert periph1/2 only", HOLD_LO);
    rd(1'b1, 16'h0006, "R8 hold bits read back");

    // external pin level reset
    ext_n = 1'b0;
    expect_out("R6 ext pin asserts at once, por/dbg untouched", SYS_LO);
    tick(4);
    expect_out("R6 ext reset held while pin low", SYS_LO);
    ext_n = 1'b1;
    expect_out("R12 ext release not immediate", SYS_LO);
    tick(1);
    expect_out("R12 ext release after one edge", SYS_LO);
    tick(1);
    expect_out("R11 all released, holds cleared", ALL_HI);
    rd(1'b1, 16'h0000, "R11 control cleared by system reset");

    // hardware watchdog strobe timing
    strobe(1);
    expect_out("R7 hwdg asserts system outputs", SYS_LO);
    tick(17);
    expect_out("R7 still held at stretch end", SYS_LO);
    tick(1);
    expect_out("R7 released after stretch", ALL_HI);
    rd(1'b0, 16'h0022, "R5 ext and hwdg flags both kept");
    rd(1'b0, 16'h0000, "R10 cleared after read");

    // remaining pulse causes
    strobe(0);
    expect_out("R2 swdg asserts system outputs", SYS_LO);
    tick(20);
    strobe(2);
    expect_out("R2 clock failure asserts system outputs", SYS_LO);
    tick(20);
    strobe(3);
    expect_out("R2 freq error asserts system outputs", SYS_LO);
    tick(20);
    expect_out("R7 released after freq error", ALL_HI);
    rd(1'b0, 16'h00d0, "R4 swdg/clkfail/freq flag positions");

    // software reset
    wr(1'b1, 16'h0001);
    expect_out("R9 no reset yet on write edge", ALL_HI);
    tick(1);
    expect_out("R9 software reset asserted", SYS_LO);
    tick(20);
    rd(1'b1, 16'h0000, "R9 request bit cleared after reset");
    rd(1'b0, 16'h0100, "R9 software flag set");

    // debug pin
    dbg_n = 1'b0;
    expect_out("R3 debug pin resets debug port only", DBG_LO);
    tick(3);
    expect_out("R3 debug reset held", DBG_LO);
    dbg_n = 1'b1;
    tick(2);
    expect_out("R3 debug released", ALL_HI);
    rd(1'b0, 16'h0000, "R3 debug pin leaves cause untouched");

    // low voltage wipes earlier flags
    strobe(1);
    tick(20);
    lvd = 1'b1;
    expect_out("R1 low voltage asserts everything", ALL_LO);
    tick(30);
    expect_out("R1 low voltage level held", ALL_LO);
    lvd = 1'b0;
    tick(2);
    expect_out("R12 release after low voltage", ALL_HI);
    rd(1'b0, 16'h0001, "R5 only power-on flag after low voltage");

    tick(2);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule